// File: doc/BRIEF.md
# Reference Divider with Selectable Staggered Comparison Taps

The block divides a reference clock by a programmable ratio and follows that stage with a three-bit binary counter. Together these produce four candidate comparison pulses at the reference rate divided by the ratio times 1, 2, 4 or 8. Two loops, called main and auxiliary, each pick one tap through their own 2-bit select.

A loop that picks a counter-derived tap different from the other loop's receives its comparison pulse on a different reference cycle. This keeps the two comparison events apart in time. The divider runs while either loop's power bit is high. When both are low it holds cleared and both outputs stay low.

All logic runs in the reference clock domain. Outputs are registered and appear one reference cycle after the terminal count that produces them.

Top module: `ref_tap_divider`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, main_ref_o and aux_ref_o are 0.
- R2: While main_pwr_i and aux_pwr_i are both 0, both outputs are 0. The ratio stage and the binary counter are cleared. After power returns, the first terminal count falls on the ratio-th enabled cycle and the counter restarts at state 0.
- R3: The divider runs when main_pwr_i is 1, when aux_pwr_i is 1, or when both are 1.
- R4: Select code 0 produces a pulse one reference cycle wide on every terminal count of the ratio stage, which is once every ratio cycles.
- R5: For select code k in 1..3, a pulse is produced on a terminal count only when the low k bits of the binary counter value (taken before it increments) equal 2^(k-1). This gives one pulse per 2^k terminal counts, each one reference cycle wide. The counter starts at 0 and advances by one on each terminal count.
- R6: When the main and auxiliary selects are different nonzero codes, the two outputs are never high in the same cycle.
- R7: A new value on ratio_i is adopted only at a terminal count, or while the divider is disabled. The count in progress finishes with the old ratio.
- R8: Ratio values below 4 are treated as 4.
- R9: Neither output is ever high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ratio_i | input | 10 | Division ratio of the first stage (4..1023) |
| main_sel_i | input | 2 | Tap select for the main loop |
| aux_sel_i | input | 2 | Tap select for the auxiliary loop |
| main_pwr_i | input | 1 | Main loop power bit |
| aux_pwr_i | input | 1 | Auxiliary loop power bit |
| main_ref_o | output | 1 | Main comparison pulse |
| aux_ref_o | output | 1 | Auxiliary comparison pulse |

## Verification
The assertions check four properties on every cycle:
- the adopted ratio never drops below four, and the first-stage count stays under it;
- outputs stay quiet while both power bits are low;
- no output pulse lasts longer than one cycle;
- two different nonzero selects never produce coincident pulses.

Pulse spacing per select code, deferred adoption of a new ratio, the restart phase after a power gap, and running on either power bit alone are visible only in the bench scenarios. There, every output cycle is compared against a cycle model built from the requirements.

// File: rtl/ref_tap_pkg.sv
package ref_tap_pkg;
  localparam int unsigned RATIO_W   = 10;
  localparam int unsigned RATIO_MIN = 4;
  localparam int unsigned OCT_STAGES = 3;
  localparam int unsigned SEL_W     = $clog2(OCT_STAGES + 1);

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [SEL_W-1:0]   tap_sel_t;
endpackage

// File: rtl/ref_prescaler.sv
module ref_prescaler #(
  parameter int unsigned W   = 10,
  parameter int unsigned MIN = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] ratio_i,
  output logic         tc_o
);
  localparam logic [W-1:0] MIN_V = W'(MIN);

  logic [W-1:0] ratio_q, cnt_q, ratio_eff;

  assign ratio_eff = (ratio_i < MIN_V) ? MIN_V : ratio_i;
  assign tc_o      = en_i && (cnt_q == ratio_q - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= MIN_V;
      cnt_q   <= '0;
    end else if (!en_i) begin
      ratio_q <= ratio_eff;
      cnt_q   <= '0;
    end else if (tc_o) begin
      ratio_q <= ratio_eff;  // new ratio only at terminal count
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + W'(1);
    end
  end

  AST_RATIO_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q >= MIN_V); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q); // R7
endmodule

// File: rtl/ref_octave_counter.sv
module ref_octave_counter #(
  parameter int unsigned STAGES = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tc_i,
  output logic [STAGES:0] taps_o
);
  logic [STAGES-1:0] oct_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      oct_q <= '0;
    else if (!en_i)   oct_q <= '0;
    else if (tc_i)    oct_q <= oct_q + STAGES'(1);
  end

  assign taps_o[0] = tc_i;

  // tap k decodes a state whose lowest set bit is k-1: taps are disjoint
  for (genvar k = 1; k <= STAGES; k++) begin : g_tap
    localparam logic [STAGES-1:0] PAT = STAGES'(1) << (k - 1);
    assign taps_o[k] = tc_i && (oct_q[k-1:0] == PAT[k-1:0]);
  end

  AST_TAPS_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(taps_o[STAGES:1]) <= 1); // R6
  AST_TAPS_NEED_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |taps_o |-> tc_i); // R5
endmodule

// File: rtl/ref_tap_select.sv
module ref_tap_select #(
  parameter int unsigned STAGES = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [STAGES:0]  taps_i,
  output logic             pulse_o
);
  logic pick;

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i <= STAGES; i++)
      if (sel_i == SEL_W'(i)) pick = taps_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= en_i && pick;
  end

  AST_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R9
endmodule

// File: rtl/ref_tap_divider.sv
module ref_tap_divider
  import ref_tap_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [9:0]   ratio_i,
  input  logic [1:0]   main_sel_i,
  input  logic [1:0]   aux_sel_i,
  input  logic         main_pwr_i,
  input  logic         aux_pwr_i,
  output logic         main_ref_o,
  output logic         aux_ref_o
);
  logic                en;
  logic                tc;
  logic [OCT_STAGES:0] taps;

  assign en = main_pwr_i | aux_pwr_i;

  ref_prescaler #(.W(RATIO_W), .MIN(RATIO_MIN)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .ratio_i(ratio_i), .tc_o(tc)
  );

  ref_octave_counter #(.STAGES(OCT_STAGES)) u_oct (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .tc_i(tc), .taps_o(taps)
  );

  ref_tap_select #(.STAGES(OCT_STAGES), .SEL_W(SEL_W)) u_sel_main (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .sel_i(main_sel_i), .taps_i(taps), .pulse_o(main_ref_o)
  );

  ref_tap_select #(.STAGES(OCT_STAGES), .SEL_W(SEL_W)) u_sel_aux (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .sel_i(aux_sel_i), .taps_i(taps), .pulse_o(aux_ref_o)
  );

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (!main_ref_o && !aux_ref_o)); // R2
  AST_NO_COINCIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_ref_o && aux_ref_o) |->
      ($past(main_sel_i) == $past(aux_sel_i) || $past(main_sel_i) == 2'd0
       || $past(aux_sel_i) == 2'd0)); // R6
endmodule

// File: tb/ref_tap_divider_test.sv
module ref_tap_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] ratio = 10'd6;
  logic [1:0] msel = '0, asel = '0;
  logic       mpwr = 1'b0, apwr = 1'b0;
  logic       mref, aref;

  always #4 clk = ~clk;

  ref_tap_divider uut (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio),
    .main_sel_i(msel), .aux_sel_i(asel),
    .main_pwr_i(mpwr), .aux_pwr_i(apwr),
    .main_ref_o(mref), .aux_ref_o(aref)
  );

  int   n_cmp = 0, n_bad = 0;
  int   mcnt = 0, mb = 0, mratio = 4;
  logic exp_m = 0, exp_a = 0, prev_m = 0, prev_a = 0;
  int   last_ms = 0, last_as = 0;
  bit   done = 0;

  function automatic int clampr(int v);
    return (v < 4) ? 4 : v;
  endfunction

  function automatic logic tapok(int k, int b);
    if (k == 0) return 1'b1;
    return (b & ((1 << k) - 1)) == (1 << (k - 1));
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(int r, int ms, int as, bit p1, bit p2, string req);
    bit tc;
    @(negedge clk);
    check(req, "main", mref, exp_m);
    check(req, "aux", aref, exp_a);
    check("R9", "main width", prev_m && mref, 1'b0);
    check("R9", "aux width", prev_a && aref, 1'b0);
    if (last_ms != last_as && last_ms != 0 && last_as != 0)
      check("R6", "coincide", mref && aref, 1'b0);
    prev_m = mref; prev_a = aref;
    ratio = 10'(r); msel = 2'(ms); asel = 2'(as); mpwr = p1; apwr = p2;
    last_ms = ms; last_as = as;
    if (!(p1 || p2)) begin
      mcnt = 0; mb = 0; mratio = clampr(r); exp_m = 0; exp_a = 0;
    end else begin
      tc = (mcnt == mratio - 1);
      exp_m = tc && tapok(ms, mb);
      exp_a = tc && tapok(as, mb);
      if (tc) begin mcnt = 0; mb = (mb + 1) % 8; mratio = clampr(r); end
      else mcnt++;
    end
  endtask

  task automatic run(int n, int r, int ms, int as, bit p1, bit p2, string req);
    for (int i = 0; i < n; i++) cyc(r, ms, as, p1, p2, req);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) begin
      @(negedge clk);
      check("R1", "main in reset", mref, 1'b0);
      check("R1", "aux in reset", aref, 1'b0);
    end
    rst_n = 1'b1;
    run(10, 6, 1, 2, 0, 0, "R1");          // R1, R2: off after reset
    run(100, 5, 0, 1, 1, 0, "R4");         // R3 main power only, R4 code 0
    run(6, 5, 2, 3, 0, 0, "R2");           // R2 clears state
    run(200, 4, 2, 3, 0, 1, "R5");         // R3 aux power only, R5
    run(120, 7, 1, 3, 1, 1, "R5");
    run(30, 7, 0, 2, 1, 1, "R7");
    run(60, 9, 0, 2, 1, 1, "R7");          // ratio changes mid count
    run(60, 2, 0, 1, 1, 0, "R8");
    run(60, 0, 3, 1, 0, 1, "R8");
    run(4, 0, 3, 1, 0, 0, "R2");
    run(60, 5, 1, 0, 1, 0, "R2");          // restart phase
    run(1023 * 9, 1023, 3, 0, 1, 1, "R5"); // full-scale ratio
    for (int s = 0; s < 40; s++) begin
      int r  = $urandom_range(0, 40);
      int ms = $urandom_range(0, 3);
      int as = $urandom_range(0, 3);
      bit p1 = 1'($urandom_range(0, 3) != 0);
      bit p2 = 1'($urandom_range(0, 1));
      run($urandom_range(20, 400), r, ms, as, p1, p2, "R6");
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule